// File: doc/BRIEF.md
# Calendar Alarm with Repeat Modes

This block watches a live calendar held in BCD (month, date, hours, minutes, seconds) and raises an alarm when that calendar agrees with a programmed alarm time. The comparison runs once per seconds tick. It assumes the calendar fields have already been updated for that second when the tick arrives. A five-bit repeat code sets how many of the fields take part in the comparison, from none (every second) up to all five (once a year).

A match sets a sticky alarm flag. The flag drives an active-low interrupt when the flag-enable bit is set. While the system runs from its backup supply, the interrupt also needs a separate backup-enable bit. Software clears the condition by reading the flags register. That read returns the flag and clears it, so the interrupt drops at once and a later read returns 0. Power-up reset clears both enable bits. An alarm that arrives straight after power-up therefore only sets the flag.

Software loads the alarm through a byte write port at these addresses:
- 0: seconds
- 1: minutes
- 2: hours
- 3: date
- 4: month
- 5: control byte, with bits [4:0] the repeat code, bit 5 the backup enable and bit 6 the flag enable

A write to address 7 changes nothing.

Top module: `cal_alarm`

## Requirements
- R1: The alarm flag can only be set by a clock edge at which `sec_tick` is 1. A calendar that matches the alarm without a tick leaves the flag at 0.
- R2: With repeat code bits [4:0] as listed, the compared fields are chosen as follows. A match sets `alarm_flag` in the cycle after the tick.
  - 5'b11111: no field is compared.
  - 5'b11110: seconds.
  - 5'b11100: seconds and minutes.
  - 5'b11000: seconds, minutes and hours.
  - 5'b10000: adds the date.
  - 5'b00000: adds the month.
- R3: Any repeat code outside the R2 table sets the flag on every tick, whatever the calendar holds.
- R4: `irq_n` is 0 only while the flag is 1 and the flag-enable bit (control bit 6) is 1. With the flag-enable bit at 0 a set flag leaves `irq_n` at 1.
- R5: A `flag_rd` pulse clears the flag, takes `irq_n` back to 1, and presents the flag's prior value on `rd_flag`. A second read presents 0.
- R6: While `on_battery` is 1, `irq_n` is 0 only if the backup-enable bit (control bit 5) is also 1. While `on_battery` is 0 that bit has no effect.
- R7: After reset the flag is 0, `irq_n` is 1, and both enable bits are 0. A matching tick then sets the flag but does not assert `irq_n`.
- R8: With the alarm date and the repeat code both written as 0, no valid calendar date (01 to 31) sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| sec_tick | input | 1 | One-cycle pulse once per second, after the calendar update |
| cur_sec | input | 8 | Live seconds, BCD 00-59 |
| cur_min | input | 8 | Live minutes, BCD 00-59 |
| cur_hour | input | 8 | Live hours, BCD 00-23 |
| cur_date | input | 8 | Live date, BCD 01-31 |
| cur_mon | input | 8 | Live month, BCD 01-12 |
| wr_en | input | 1 | Alarm register write strobe |
| wr_addr | input | 3 | Alarm register address |
| wr_data | input | 8 | Alarm register write data |
| flag_rd | input | 1 | Flags register read strobe |
| on_battery | input | 1 | High while running from the backup supply |
| alarm_flag | output | 1 | Live alarm flag |
| rd_flag | output | 1 | Flag value returned by the most recent flags read |
| irq_n | output | 1 | Alarm interrupt, active low |

## Verification
All 32 repeat codes are crossed with six calendar vectors.
- In vector k, the k lowest fields equal the alarm time and field k differs from it. In the sixth vector every field matches.
- This separates each legal code's compare depth from its neighbours' depths.
- It also shows that every illegal code behaves like the every-second code.

Further sequences cover the following:
- The flag-enable and backup-enable gating under both supply states.
- The two-read clearing order.
- A sweep of every valid date against the disabled setting.
- A matching calendar held without a tick.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFLD = 5;   // sec, min, hour, date, month
  localparam int FW   = 8;   // BCD byte per field
  localparam int RW   = 5;   // repeat code width
  localparam int CW   = 7;   // control byte bits kept
  localparam int AW   = 3;   // write address width
  localparam int DEPW = $clog2(NFLD + 1);

  // number of low-order fields that must agree for a given repeat code
  function automatic logic [DEPW-1:0] rpt_depth(input logic [RW-1:0] code);
    case (code)
      5'b11111: rpt_depth = DEPW'(0);
      5'b11110: rpt_depth = DEPW'(1);
      5'b11100: rpt_depth = DEPW'(2);
      5'b11000: rpt_depth = DEPW'(3);
      5'b10000: rpt_depth = DEPW'(4);
      5'b00000: rpt_depth = DEPW'(5);
      default:  rpt_depth = DEPW'(0);
    endcase
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [FW-1:0]            wr_data,
  output logic [NFLD-1:0][FW-1:0]  al_fld,
  output logic [RW-1:0]            rpt,
  output logic                     ben,
  output logic                     fen
);
  localparam int CTL_ADDR = NFLD;

  logic [NFLD-1:0][FW-1:0] fld_q, fld_d;
  logic [CW-1:0]           ctl_q, ctl_d;

  generate
    for (genvar k = 0; k < NFLD; k++) begin : g_fld
      always_comb begin
        fld_d[k] = fld_q[k];
        if (wr_en && (wr_addr == AW'(k))) fld_d[k] = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q[k] <= '0;
        else        fld_q[k] <= fld_d[k];
      end
    end
  endgenerate

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && (wr_addr == AW'(CTL_ADDR))) ctl_d = wr_data[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign al_fld = fld_q;
  assign rpt    = ctl_q[RW-1:0];
  assign ben    = ctl_q[RW];
  assign fen    = ctl_q[RW+1];
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  logic [NFLD-1:0][FW-1:0] cur_fld,
  input  logic [NFLD-1:0][FW-1:0] al_fld,
  input  logic [RW-1:0]           rpt,
  output logic                    hit
);
  logic [DEPW-1:0] depth;
  logic [NFLD-1:0] eq;
  logic [NFLD-1:0] need;

  assign depth = rpt_depth(rpt);

  generate
    for (genvar k = 0; k < NFLD; k++) begin : g_cmp
      assign eq[k]   = (cur_fld[k] == al_fld[k]);
      assign need[k] = (DEPW'(k) < depth);
    end
  endgenerate

  assign hit = &(eq | ~need);
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic flag_rd,
  input  logic fen,
  input  logic ben,
  input  logic on_battery,
  output logic flag,
  output logic rd_flag,
  output logic irq_n
);
  logic flag_q, flag_d;
  logic rdv_q, rdv_d;
  logic set_ev;

  assign set_ev = tick & hit;

  always_comb begin
    flag_d = flag_q;
    rdv_d  = rdv_q;
    if (flag_rd) begin
      rdv_d  = flag_q;
      flag_d = 1'b0;
    end
    if (set_ev) flag_d = 1'b1;   // a new match wins over a same-cycle read
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      rdv_q  <= rdv_d;
    end
  end

  assign flag    = flag_q;
  assign rd_flag = rdv_q;
  assign irq_n   = ~(flag_q & fen & (ben | ~on_battery));

  assert_set_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit) |=> flag);
  assert_rise_needs_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !(tick && hit)) |=> (!flag && irq_n));
  assert_read_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd |=> (rd_flag == $past(flag)));
  assert_backup_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && !ben) |-> irq_n);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [7:0]    cur_sec,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_hour,
  input  logic [7:0]    cur_date,
  input  logic [7:0]    cur_mon,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          flag_rd,
  input  logic          on_battery,
  output logic          alarm_flag,
  output logic          rd_flag,
  output logic          irq_n
);
  // reset asserts at once, releases on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NFLD-1:0][FW-1:0] cur_fld, al_fld;
  logic [RW-1:0]           rpt;
  logic                    ben, fen, hit;

  assign cur_fld = {cur_mon, cur_date, cur_hour, cur_min, cur_sec};

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .al_fld(al_fld), .rpt(rpt), .ben(ben), .fen(fen)
  );

  alarm_match u_match (
    .cur_fld(cur_fld), .al_fld(al_fld), .rpt(rpt), .hit(hit)
  );

  alarm_flag_ctl u_flag (
    .clk(clk), .rst_n(rst_int_n), .tick(sec_tick), .hit(hit),
    .flag_rd(flag_rd), .fen(fen), .ben(ben), .on_battery(on_battery),
    .flag(alarm_flag), .rd_flag(rd_flag), .irq_n(irq_n)
  );

  assert_irq_needs_fen_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fen |-> irq_n);
  assert_disabled_no_set_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sec_tick && rpt == '0 && al_fld[3] == '0 && cur_date != '0 && !alarm_flag)
      |=> !alarm_flag);
endmodule

// File: tb/cal_alarm_bench.sv
module cal_alarm_bench;
  logic       clk = 1'b0;
  logic       rst_n, sec_tick, wr_en, flag_rd, on_battery;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_date, cur_mon, wr_data;
  logic [2:0] wr_addr;
  logic       alarm_flag, rd_flag, irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cal_alarm u_cal_alarm (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_mon(cur_mon),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_rd(flag_rd), .on_battery(on_battery),
    .alarm_flag(alarm_flag), .rd_flag(rd_flag), .irq_n(irq_n)
  );

  logic [7:0] al_v [5];
  logic [7:0] mm_v [5];

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic set_time(input int d);
    // fields below d agree with the alarm, field d differs
    logic [7:0] v [5];
    for (int k = 0; k < 5; k++) v[k] = (k < d) ? al_v[k] : (k == d ? mm_v[k] : al_v[k]);
    cur_sec = v[0]; cur_min = v[1]; cur_hour = v[2]; cur_date = v[3]; cur_mon = v[4];
  endtask

  function automatic int depth_of(input logic [4:0] c);
    case (c)
      5'h1F: return 0;
      5'h1E: return 1;
      5'h1C: return 2;
      5'h18: return 3;
      5'h10: return 4;
      5'h00: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    al_v = '{8'h45, 8'h30, 8'h09, 8'h17, 8'h05};
    mm_v = '{8'h46, 8'h31, 8'h10, 8'h18, 8'h06};
    rst_n = 1'b0; sec_tick = 0; wr_en = 0; flag_rd = 0; on_battery = 0;
    wr_addr = '0; wr_data = '0;
    cur_sec = 8'h00; cur_min = 8'h00; cur_hour = 8'h00; cur_date = 8'h01; cur_mon = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: reset state, then a match with enables still cleared
    chk("R7 flag after reset", alarm_flag, 1'b0);
    chk("R7 irq after reset", irq_n, 1'b1);
    for (int k = 0; k < 5; k++) wr(3'(k), al_v[k]);
    wr(3'd5, 8'h1F);               // every second, enables left 0
    tick();
    chk("R7 flag set after power-up", alarm_flag, 1'b1);
    chk("R7 irq held off", irq_n, 1'b1);
    rd(); rd();

    // R2 / R3 / R4 / R5: all repeat codes against each compare depth
    for (int c = 0; c < 32; c++) begin
      for (int d = 0; d <= 5; d++) begin
        logic ex;
        ex = (d >= depth_of(5'(c)));
        wr(3'd5, {2'b01, 1'b0, 5'(c)});
        set_time(d);
        tick();
        chk((depth_of(5'(c)) == 0 && c != 31) ? "R3 illegal code" : "R2 repeat depth",
            alarm_flag, ex);
        chk("R4 irq follows flag", irq_n, ~ex);
        rd();
        chk("R5 first read value", rd_flag, ex);
        chk("R5 irq released", irq_n, 1'b1);
        rd();
        chk("R5 second read zero", rd_flag, 1'b0);
      end
    end

    // R1: matching calendar without a tick
    wr(3'd5, 8'h40);
    set_time(5);
    repeat (4) @(negedge clk);
    chk("R1 no tick no flag", alarm_flag, 1'b0);
    tick();
    chk("R1 tick sets flag", alarm_flag, 1'b1);

    // R4: flag enable off
    wr(3'd5, 8'h00);
    chk("R4 fen off irq", irq_n, 1'b1);
    chk("R4 flag kept", alarm_flag, 1'b1);

    // R6: backup supply gating
    on_battery = 1'b1;
    wr(3'd5, 8'h40);
    chk("R6 battery no ben", irq_n, 1'b1);
    wr(3'd5, 8'h60);
    chk("R6 battery with ben", irq_n, 1'b0);
    on_battery = 1'b0;
    wr(3'd5, 8'h40);
    @(negedge clk);
    chk("R6 mains ignores ben", irq_n, 1'b0);
    rd(); rd();

    // R8: date 0 and repeat 0 disables, sweep valid dates
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h40);
    set_time(5);
    for (int t = 1; t <= 31; t++) begin
      cur_date = 8'(((t / 10) << 4) | (t % 10));
      tick();
      chk("R8 disabled alarm", alarm_flag, 1'b0);
    end

    finish_run();
  end
endmodule